// File: doc/BRIEF.md
# Double-Buffered Four-Channel Analog Output Register Front End

This block is the host-facing register file for four analog output channels. A 16-bit register bus with separate write and read strobes reaches a mode register, a shared configuration register that carries a polarity bit and a gain bit for every channel, and one write-only data register per channel. Every write lands in a shadow copy first. The active copies feed the converters. They change only when a register update event moves the shadows across.

In buffered mode the bus reads act as triggers. A read of the configuration register moves the polarity and gain bits to the active side. A read of the mode register moves all four data shadows to the active side on one clock edge, so every channel changes at the same moment. In direct mode a write reaches the active copy on its own clock edge. While the converter enable is clear, the active side is held at zero and the update triggers do nothing. The shadows still accept writes, so a host can preload values before it enables the outputs.

Top module: `aod_dac_regs`

## Requirements
- R1: After a synchronous active-low reset, all active codes, polarity bits, gain bits and the enable output are zero, and reads of the mode register (0x02) and the configuration register (0x12) return zero.
- R2: A write to byte address 0x14 + 2*n changes the shadow of channel n only; the shadows of the other channels keep their values.
- R3: With enable and buffered mode set, a data write leaves every active code unchanged. A later read of address 0x02 copies all four shadows to the active codes on the same clock edge.
- R4: In the configuration register, channel n's bipolar bit is bit 7-n and its gain bit is bit 11-n. With enable and buffered mode set, a write to 0x12 leaves the active bits unchanged and a read of 0x12 applies them.
- R5: With enable set and buffered mode clear, a data write or configuration write reaches the active outputs on the clock edge that takes the write.
- R6: In any cycle where enable is clear, the next cycle's active codes, polarity and gain bits are all zero, and reads of 0x02 or 0x12 copy nothing.
- R7: The mode register at 0x02 holds enable in bit 1 and buffered mode in bit 0; read data appears one cycle after the read strobe: bits {enable, buffered} for 0x02, the configuration shadow for 0x12, and zero for any other address or when no read occurs.
- R8: A read of 0x12 leaves the active codes untouched, and a read of 0x02 leaves the active polarity and gain bits untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| dac_en_o | output | 1 | Converter enable |
| dac_code_o | output | NCH*DW | Active codes, channel n in bits n*DW +: DW |
| dac_bipolar_o | output | NCH | Active bipolar bit per channel |
| dac_gain_o | output | NCH | Active gain bit per channel |

## Verification
The bench uses an asymmetric configuration word, so a design that wires the polarity or gain bits in forward order instead of reversed order shows the wrong channel. It writes one channel between two update reads. A decoder that hits a neighbour, or a copy that moves only part of the set, then shows up as a stale or corrupted code. It preloads shadows while the outputs are disabled and then enables them. This exposes a design that lets writes or triggers through while disabled, or that loses the shadows when the active side is cleared. It also switches to direct mode and checks that a write appears after one edge, not after a later trigger.

// File: rtl/aod_pkg.sv
// Package: shared address map, bit positions and decode type for the
// analog output register front end. Assumes a byte-addressed 16-bit bus.
package aod_pkg;
    localparam int unsigned BUS_W        = 16;
    localparam int unsigned ADR_MODE     = 'h02;
    localparam int unsigned ADR_CFG      = 'h12;
    localparam int unsigned ADR_DATA0    = 'h14;
    localparam int unsigned MODE_EN_BIT  = 1;
    localparam int unsigned MODE_BUF_BIT = 0;
    localparam int unsigned POL_TOP      = 7;
    localparam int unsigned GAIN_TOP     = 11;

    typedef struct packed {
        logic wr_mode;
        logic wr_cfg;
        logic rd_mode;
        logic rd_cfg;
    } aod_dec_t;
endpackage

// File: rtl/aod_regdec.sv
// Module: address decoder. Turns one bus access into per-register strobes.
// Assumes at most one of write or read is active in a cycle.
module aod_regdec #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned ADDR_W = 6
) (
    input  logic                  bus_wr_i,
    input  logic                  bus_rd_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    output aod_pkg::aod_dec_t     dec_o,
    output logic [NCH-1:0]        data_wr_o
);
    import aod_pkg::*;

    // Purpose: strobes for the mode and configuration registers.
    always_comb begin
        dec_o.wr_mode = bus_wr_i && (bus_addr_i == ADDR_W'(ADR_MODE));
        dec_o.wr_cfg  = bus_wr_i && (bus_addr_i == ADDR_W'(ADR_CFG));
        dec_o.rd_mode = bus_rd_i && (bus_addr_i == ADDR_W'(ADR_MODE));
        dec_o.rd_cfg  = bus_rd_i && (bus_addr_i == ADDR_W'(ADR_CFG));
    end

    // Purpose: one write strobe per channel data register, 2 bytes apart.
    for (genvar g = 0; g < NCH; g++) begin : g_dsel
        localparam int unsigned ADR_N = ADR_DATA0 + 2 * g;
        assign data_wr_o[g] = bus_wr_i && (bus_addr_i == ADDR_W'(ADR_N));
    end
endmodule

// File: rtl/aod_chan.sv
// Module: one channel's data shadow and active code.
// Assumes en_i and buf_i are registered mode bits; copy_i is the
// broadcast update trigger shared by all channels.
module aod_chan #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          buf_i,
    input  logic          wr_i,
    input  logic          copy_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] shadow_o,
    output logic [DW-1:0] active_o
);
    // Purpose: shadow takes every write, whatever the mode.
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_o <= '0;
        else if (wr_i) shadow_o <= wdata_i;
    end

    // Purpose: active code is zero while disabled, else direct or copied.
    always_ff @(posedge clk) begin
        if (!rst_n)              active_o <= '0;
        else if (!en_i)          active_o <= '0;
        else if (wr_i && !buf_i) active_o <= wdata_i;
        else if (copy_i)         active_o <= shadow_o;
    end
endmodule

// File: rtl/aod_ctrl.sv
// Module: mode register, configuration shadow, per-channel active
// polarity/gain bits (reversed layout) and registered read data.
// Assumes NCH <= 4 so bit POL_TOP-n and GAIN_TOP-n stay in their nibbles.
module aod_ctrl #(
    parameter int unsigned NCH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  aod_pkg::aod_dec_t          dec_i,
    input  logic [aod_pkg::BUS_W-1:0]  wdata_i,
    output logic                       en_o,
    output logic                       buf_o,
    output logic [aod_pkg::BUS_W-1:0]  cfg_o,
    output logic [NCH-1:0]             pol_o,
    output logic [NCH-1:0]             gain_o,
    output logic [aod_pkg::BUS_W-1:0]  rdata_o
);
    import aod_pkg::*;

    logic [BUS_W-1:0] mode_word;

    // Purpose: mode register (enable and buffered bits).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= 1'b0;
            buf_o <= 1'b0;
        end else if (dec_i.wr_mode) begin
            en_o  <= wdata_i[MODE_EN_BIT];
            buf_o <= wdata_i[MODE_BUF_BIT];
        end
    end

    // Purpose: configuration shadow word.
    always_ff @(posedge clk) begin
        if (!rst_n)            cfg_o <= '0;
        else if (dec_i.wr_cfg) cfg_o <= wdata_i;
    end

    // Purpose: assemble the mode register read value.
    always_comb begin
        mode_word               = '0;
        mode_word[MODE_EN_BIT]  = en_o;
        mode_word[MODE_BUF_BIT] = buf_o;
    end

    // Purpose: registered read data, zero unless a mapped read occurs.
    always_ff @(posedge clk) begin
        if (!rst_n)             rdata_o <= '0;
        else if (dec_i.rd_mode) rdata_o <= mode_word;
        else if (dec_i.rd_cfg)  rdata_o <= cfg_o;
        else                    rdata_o <= '0;
    end

    // Purpose: per-channel active polarity and gain bits.
    for (genvar g = 0; g < NCH; g++) begin : g_cbit
        localparam int unsigned PB = POL_TOP - g;
        localparam int unsigned GB = GAIN_TOP - g;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pol_o[g]  <= 1'b0;
                gain_o[g] <= 1'b0;
            end else if (!en_o) begin
                pol_o[g]  <= 1'b0;
                gain_o[g] <= 1'b0;
            end else if (dec_i.wr_cfg && !buf_o) begin
                pol_o[g]  <= wdata_i[PB];
                gain_o[g] <= wdata_i[GB];
            end else if (dec_i.rd_cfg) begin
                pol_o[g]  <= cfg_o[PB];
                gain_o[g] <= cfg_o[GB];
            end
        end
    end
endmodule

// File: rtl/aod_dac_regs.sv
// Module: top of the double-buffered analog output register front end.
// Assumes DW <= 16 and NCH <= 4; the converter link is outside.
module aod_dac_regs #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned DW     = 16,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [15:0]       bus_wdata_i,
    output logic [15:0]       bus_rdata_o,
    output logic              dac_en_o,
    output logic [NCH*DW-1:0] dac_code_o,
    output logic [NCH-1:0]    dac_bipolar_o,
    output logic [NCH-1:0]    dac_gain_o
);
    import aod_pkg::*;

    aod_dec_t          dec;
    logic [NCH-1:0]    data_wr;
    logic              mode_en;
    logic              mode_buf;
    logic [BUS_W-1:0]  cfg_shadow;
    logic [NCH*DW-1:0] shadow_bus;

    aod_regdec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .bus_wr_i   (bus_wr_i),
        .bus_rd_i   (bus_rd_i),
        .bus_addr_i (bus_addr_i),
        .dec_o      (dec),
        .data_wr_o  (data_wr)
    );

    aod_ctrl #(.NCH(NCH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_i   (dec),
        .wdata_i (bus_wdata_i),
        .en_o    (mode_en),
        .buf_o   (mode_buf),
        .cfg_o   (cfg_shadow),
        .pol_o   (dac_bipolar_o),
        .gain_o  (dac_gain_o),
        .rdata_o (bus_rdata_o)
    );

    // Purpose: one shadow/active pair per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        aod_chan #(.DW(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (mode_en),
            .buf_i    (mode_buf),
            .wr_i     (data_wr[g]),
            .copy_i   (dec.rd_mode),
            .wdata_i  (bus_wdata_i[DW-1:0]),
            .shadow_o (shadow_bus[g*DW +: DW]),
            .active_o (dac_code_o[g*DW +: DW])
        );
    end

    assign dac_en_o = mode_en;
endmodule

// File: rtl/aod_checker.sv
// Module: property checker for aod_dac_regs, attached by bind below.
module aod_checker #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned DW     = 16,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic              en,
    input logic              buf_mode,
    input logic [15:0]       cfg_q,
    input logic [NCH*DW-1:0] shadow_bus,
    input logic [NCH*DW-1:0] code_bus,
    input logic [NCH-1:0]    pol,
    input logic [NCH-1:0]    gain
);
    import aod_pkg::*;

    logic [NCH-1:0] exp_pol;
    logic [NCH-1:0] exp_gain;
    logic           rd_mode;
    logic           rd_cfg;
    logic           wr_d0;

    // Purpose: reversed-order view of the configuration shadow.
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            exp_pol[n]  = cfg_q[POL_TOP - n];
            exp_gain[n] = cfg_q[GAIN_TOP - n];
        end
    end

    assign rd_mode = bus_rd && (bus_addr == ADDR_W'(ADR_MODE));
    assign rd_cfg  = bus_rd && (bus_addr == ADDR_W'(ADR_CFG));
    assign wr_d0   = bus_wr && (bus_addr == ADDR_W'(ADR_DATA0));

    a_r6_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (code_bus == '0) && (pol == '0) && (gain == '0));

    a_r3_hold_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        (en && buf_mode && !rd_mode) |=> $stable(code_bus));

    a_r3_copy_all: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd_mode) |=> code_bus == $past(shadow_bus));

    a_r4_apply_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd_cfg) |=> (pol == $past(exp_pol)) && (gain == $past(exp_gain)));

    a_r5_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !buf_mode && wr_d0) |=> code_bus[DW-1:0] == $past(bus_wdata[DW-1:0]));

    a_r7_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 16'h0000);
endmodule

bind aod_dac_regs aod_checker #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr_i),
    .bus_rd     (bus_rd_i),
    .bus_addr   (bus_addr_i),
    .bus_wdata  (bus_wdata_i),
    .bus_rdata  (bus_rdata_o),
    .en         (mode_en),
    .buf_mode   (mode_buf),
    .cfg_q      (cfg_shadow),
    .shadow_bus (shadow_bus),
    .code_bus   (dac_code_o),
    .pol        (dac_bipolar_o),
    .gain       (dac_gain_o)
);

// File: tb/aod_dac_regs_tb_top.sv
`timescale 1ns/1ps
module aod_dac_regs_tb_top;
    localparam int NCH = 4;
    localparam int DW  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        en_o;
    logic [63:0] code;
    logic [3:0]  pol;
    logic [3:0]  gain;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit done = 0;

    // behavioural reference state
    int          m_sh[4];
    int          m_act[4];
    int          m_cfg;
    int          m_cfg_act;
    bit          m_en;
    bit          m_buf;
    int          m_rdata;

    always #2.5 clk = ~clk;

    aod_dac_regs #(.NCH(NCH), .DW(DW), .ADDR_W(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .dac_en_o(en_o), .dac_code_o(code), .dac_bipolar_o(pol),
        .dac_gain_o(gain)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: advances on every rising edge.
    always @(posedge clk) begin
        bit oe, ob;
        int ocfg, r;
        started = 1;
        if (!rst_n) begin
            foreach (m_sh[n]) begin m_sh[n] = 0; m_act[n] = 0; end
            m_cfg = 0; m_cfg_act = 0; m_en = 0; m_buf = 0; m_rdata = 0;
        end else begin
            oe = m_en; ob = m_buf; ocfg = m_cfg; r = 0;
            if (rd && addr == 6'h02) r = (int'(oe) << 1) | int'(ob);
            else if (rd && addr == 6'h12) r = ocfg;
            if (wr) begin
                if (addr == 6'h02) begin m_en = wdata[1]; m_buf = wdata[0]; end
                else if (addr == 6'h12) begin
                    m_cfg = wdata;
                    if (oe && !ob) m_cfg_act = wdata;
                end else begin
                    for (int n = 0; n < 4; n++)
                        if (addr == 6'(20 + 2*n)) begin
                            m_sh[n] = wdata;
                            if (oe && !ob) m_act[n] = wdata;
                        end
                end
            end
            if (rd && oe && addr == 6'h02)
                for (int n = 0; n < 4; n++) m_act[n] = m_sh[n];
            if (rd && oe && addr == 6'h12) m_cfg_act = ocfg;
            if (!oe) begin
                for (int n = 0; n < 4; n++) m_act[n] = 0;
                m_cfg_act = 0;
            end
            m_rdata = r;
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        logic [63:0] ec;
        logic [3:0]  ep, eg;
        if (started && !done) begin
            for (int n = 0; n < 4; n++) begin
                ec[n*16 +: 16] = 16'(m_act[n]);
                ep[n] = m_cfg_act[7-n];
                eg[n] = m_cfg_act[11-n];
            end
            chk("R3 model codes", code, ec);
            chk("R4 model pol", {60'b0, pol}, {60'b0, ep});
            chk("R4 model gain", {60'b0, gain}, {60'b0, eg});
            chk("R7 model rdata", {48'b0, rdata}, {48'b0, 16'(m_rdata)});
            chk("R7 model enable", {63'b0, en_o}, {63'b0, m_en});
        end
    end

    task automatic bus_wr(logic [5:0] a, logic [15:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(negedge clk); wr = 0;
    endtask

    task automatic bus_rd(logic [5:0] a);
        @(negedge clk); rd = 1; addr = a;
        @(negedge clk); rd = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 codes", code, 64'h0);
        chk("R1 pol/gain", {56'b0, pol, gain}, 64'h0);
        chk("R1 enable", {63'b0, en_o}, 64'h0);
        bus_rd(6'h02); chk("R1 mode read", {48'b0, rdata}, 64'h0);
        bus_rd(6'h12); chk("R1 cfg read", {48'b0, rdata}, 64'h0);

        // R6: preload while disabled, triggers ignored
        bus_wr(6'h14, 16'h1111); bus_wr(6'h16, 16'h2222);
        bus_wr(6'h18, 16'h3333); bus_wr(6'h1A, 16'h4444);
        bus_wr(6'h12, 16'h0C10);
        bus_rd(6'h02); chk("R6 codes stay zero", code, 64'h0);
        bus_rd(6'h12); chk("R7 cfg readback", {48'b0, rdata}, 64'h0C10);
        chk("R6 cfg bits stay zero", {56'b0, pol, gain}, 64'h0);

        // R3: enable buffered, copy on mode read
        bus_wr(6'h02, 16'h0003);
        chk("R3 no copy before trigger", code, 64'h0);
        bus_rd(6'h02);
        chk("R7 mode readback", {48'b0, rdata}, 64'h0003);
        chk("R3 all channels copied", code, 64'h4444_3333_2222_1111);
        chk("R8 mode read leaves cfg bits", {56'b0, pol, gain}, 64'h0);

        // R2: one channel written, others untouched
        bus_wr(6'h18, 16'hABCD);
        chk("R3 buffered write held", code, 64'h4444_3333_2222_1111);
        bus_rd(6'h02);
        chk("R2 only channel 2 changed", code, 64'h4444_ABCD_2222_1111);

        // R4: reversed bit layout, applied on cfg read
        chk("R4 bits before apply", {56'b0, pol, gain}, 64'h0);
        bus_rd(6'h12);
        chk("R4 bipolar reversed", {60'b0, pol}, 64'h8);
        chk("R4 gain reversed", {60'b0, gain}, 64'h3);
        chk("R8 cfg read leaves codes", code, 64'h4444_ABCD_2222_1111);

        // R5: direct mode
        bus_wr(6'h02, 16'h0002);
        bus_wr(6'h16, 16'h5A5A);
        chk("R5 direct data write", code, 64'h4444_ABCD_5A5A_1111);
        bus_wr(6'h12, 16'h0180);
        chk("R5 direct cfg bipolar", {60'b0, pol}, 64'h1);
        chk("R5 direct cfg gain", {60'b0, gain}, 64'h8);

        // R6: disable clears, shadows kept
        bus_wr(6'h02, 16'h0000);
        @(negedge clk);
        chk("R6 disable clears codes", code, 64'h0);
        chk("R6 disable clears bits", {56'b0, pol, gain}, 64'h0);
        bus_wr(6'h02, 16'h0001);
        bus_rd(6'h02);
        chk("R7 mode read buffered only", {48'b0, rdata}, 64'h0001);
        chk("R6 trigger ignored with buffered only", code, 64'h0);
        bus_wr(6'h02, 16'h0003);
        bus_rd(6'h02);
        chk("R2 shadows survive disable", code, 64'h4444_ABCD_5A5A_1111);

        // R7: unmapped and write-only addresses read zero
        bus_rd(6'h14); chk("R7 data reg reads zero", {48'b0, rdata}, 64'h0);
        bus_rd(6'h3E); chk("R7 unmapped reads zero", {48'b0, rdata}, 64'h0);
        @(negedge clk);
        finish_run();
    end
endmodule